// File: doc/BRIEF.md
# SCSI Selection Message and Command Sender

After the bus has been won and the target selected as initiator, this block carries out the information-transfer part of a select command. Depending on the command kind it either goes straight to the command phase, or first waits for the target to enter message-out and sends one message byte. It then sends command bytes taken from the head of a byte FIFO. The number of command bytes expected is looked up from the opcode group of the first command byte.

Each byte leaves through a one-cycle request to a separate byte-handshake engine. That engine performs the REQ/ACK timing and reports back when the byte has been taken. The block follows REQ and the three phase lines (MSG, C/D, I/O packed as `phase_i[2:0]` with MSG in bit 2, C/D in bit 1 and I/O in bit 0). It keeps a sequence-step value that shows how far the operation got. It ends with a one-cycle completion pulse that is marked either function-complete or bus-service.

Top module: `scsi_sel_cmd_sender`

## Requirements
- R1: After reset `busy_o`, `atn_o`, `hs_go_o`, `fifo_pop_o` and `done_o` are 0 and `seq_step_o` is 0.
- R2: A `start_i` pulse while idle clears `seq_step_o` to 0 and raises `busy_o`. `atn_o` goes to 1 for kinds 1 (select with attention) and 2 (select with attention and stop), and to 0 for kind 0 (plain select). Kind 3 behaves as kind 0.
- R3: For a plain select no message byte is sent. The first REQ seen in the command phase (code 3'b010) sends the FIFO head as the first command byte.
- R4: For kind 1, a REQ in the message-out phase (code 3'b110) lowers `atn_o` by the cycle in which the message byte is requested, and one byte is sent. For kind 2, `atn_o` stays at 1.
- R5: With a message expected, a REQ in any phase other than message-out ends the operation at once: `done_o` pulses with `done_bus_svc_o`=0, no byte is requested, and the step stays 0.
- R6: Kind 2 sets the step to 1 and pulses `done_o` with `done_bus_svc_o`=0 as soon as the message byte has been taken.
- R7: The command length is taken from the first command byte, bits [7:5]. Group 0 gives 6 bytes, groups 1 and 2 give 10, group 5 gives 12, and any other group gives 6.
- R8: The step becomes 3 when the first command byte is requested. The step only ever takes the values 0, 1, 3 and 4.
- R9: Each command byte taken lowers the remaining length by one. The step becomes 4 when the byte that brings the length to zero is taken.
- R10: A REQ in a phase other than command while command bytes are expected sets the step to 4 if no bytes remain, and leaves it unchanged otherwise. The block then waits for REQ to go low, and only then pulses `done_o` with `done_bus_svc_o`=1.
- R11: `hs_go_o` is a one-cycle pulse. It coincides with `fifo_pop_o`, and `hs_byte_o` holds the FIFO head from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| kind_i | input | 2 | 0 plain, 1 with attention, 2 with attention and stop |
| req_i | input | 1 | Target REQ line |
| phase_i | input | 3 | {MSG, C/D, I/O} phase lines |
| fifo_data_i | input | 8 | Head byte of the FIFO |
| fifo_pop_o | output | 1 | Advance the FIFO head |
| hs_go_o | output | 1 | Send-byte request to the handshake engine |
| hs_byte_o | output | 8 | Byte to send |
| hs_done_i | input | 1 | Handshake engine finished the byte |
| atn_o | output | 1 | ATN drive |
| busy_o | output | 1 | Operation in progress |
| seq_step_o | output | 3 | Sequence step (0, 1, 3, 4) |
| done_o | output | 1 | Completion pulse |
| done_bus_svc_o | output | 1 | With `done_o`: 1 bus service, 0 function complete |

## Verification
The hardest cases to reach are a target that leaves the command phase early, with bytes still owed, and a target that skips message-out entirely. Both depend on the phase code present at the exact REQ edge, not on the data. The bench therefore plays the target. For each table row it chooses how many command-phase REQs to grant before it presents a status-phase REQ. It checks that completion waits for that REQ to fall, and that the step reflects whether the length was used up.

// File: rtl/scsi_sel_cmd_sender.sv
module scsi_sel_cmd_sender #(
  parameter int          LEN_W     = 4,
  parameter logic [2:0]  PH_CMD    = 3'b010,
  parameter logic [2:0]  PH_MSGOUT = 3'b110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] kind_i,
  input  logic       req_i,
  input  logic [2:0] phase_i,
  input  logic [7:0] fifo_data_i,
  output logic       fifo_pop_o,
  output logic       hs_go_o,
  output logic [7:0] hs_byte_o,
  input  logic       hs_done_i,
  output logic       atn_o,
  output logic       busy_o,
  output logic [2:0] seq_step_o,
  output logic       done_o,
  output logic       done_bus_svc_o
);

  localparam logic [1:0] K_ATN  = 2'd1;
  localparam logic [1:0] K_STOP = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_MSG_REQ, S_MSG_XFER, S_CMD_REQ, S_CMD_XFER, S_REQ_LOW
  } st_t;

  st_t              st;
  logic [1:0]       kind_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       seq_q;
  logic             atn_q, go_q, done_q, svc_q;
  logic [7:0]       byte_q;

  function automatic logic [LEN_W-1:0] cdb_len(input logic [7:0] op);
    case (op[7:5])
      3'd1, 3'd2: cdb_len = LEN_W'(10);
      3'd5:       cdb_len = LEN_W'(12);
      default:    cdb_len = LEN_W'(6);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= '0;
      len_q  <= '0;
      seq_q  <= '0;
      atn_q  <= 1'b0;
      go_q   <= 1'b0;
      byte_q <= '0;
      done_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          kind_q <= kind_i;
          seq_q  <= '0;
          if (kind_i == K_ATN || kind_i == K_STOP) begin
            atn_q <= 1'b1;
            st    <= S_MSG_REQ;
          end else begin
            atn_q <= 1'b0;
            len_q <= cdb_len(fifo_data_i);
            st    <= S_CMD_REQ;
          end
        end
        S_MSG_REQ: if (req_i) begin
          if (phase_i != PH_MSGOUT) begin
            done_q <= 1'b1;
            svc_q  <= 1'b0;
            st     <= S_IDLE;
          end else begin
            if (kind_q == K_ATN) atn_q <= 1'b0;
            go_q   <= 1'b1;
            byte_q <= fifo_data_i;
            st     <= S_MSG_XFER;
          end
        end
        S_MSG_XFER: if (hs_done_i) begin
          if (kind_q == K_STOP) begin
            seq_q  <= 3'd1;
            done_q <= 1'b1;
            svc_q  <= 1'b0;
            st     <= S_IDLE;
          end else begin
            len_q <= cdb_len(fifo_data_i);
            st    <= S_CMD_REQ;
          end
        end
        S_CMD_REQ: if (req_i) begin
          if (phase_i != PH_CMD) begin
            if (len_q == '0) seq_q <= 3'd4;
            st <= S_REQ_LOW;
          end else begin
            if (seq_q < 3'd3) seq_q <= 3'd3;
            go_q   <= 1'b1;
            byte_q <= fifo_data_i;
            st     <= S_CMD_XFER;
          end
        end
        S_CMD_XFER: if (hs_done_i) begin
          if (len_q != '0) begin
            len_q <= len_q - 1'b1;
            if (len_q == LEN_W'(1)) seq_q <= 3'd4;
          end
          st <= S_CMD_REQ;
        end
        S_REQ_LOW: if (!req_i) begin
          done_q <= 1'b1;
          svc_q  <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fifo_pop_o     = go_q;
  assign hs_go_o        = go_q;
  assign hs_byte_o      = byte_q;
  assign atn_o          = atn_q;
  assign busy_o         = (st != S_IDLE);
  assign seq_step_o     = seq_q;
  assign done_o         = done_q;
  assign done_bus_svc_o = svc_q;

  p_go_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_go_o |=> !hs_go_o);

  p_start_clears_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st == S_IDLE) |=> (seq_q == 3'd0 && busy_o));

  p_atn_low_on_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_go_o && st == S_MSG_XFER && kind_q == K_ATN) |-> !atn_o);

  p_step_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q == 3'd0 || seq_q == 3'd1 || seq_q == 3'd3 || seq_q == 3'd4);

  p_step_one_only_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == 3'd1) |-> (kind_q == K_STOP));

  p_svc_after_req_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_bus_svc_o) |-> !$past(req_i));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/scsi_sel_cmd_sender_tb.sv
module scsi_sel_cmd_sender_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] kind_i = 2'd0;
  logic       req_i = 1'b0;
  logic [2:0] phase_i = 3'b000;
  logic [7:0] fifo_data_i;
  logic       fifo_pop_o, hs_go_o, hs_done_i, atn_o, busy_o, done_o, done_bus_svc_o;
  logic [7:0] hs_byte_o;
  logic [2:0] seq_step_o;

  localparam logic [2:0] PH_CMD = 3'b010, PH_MSG = 3'b110, PH_STAT = 3'b011;
  localparam logic [7:0] MSG_BYTE = 8'hC0;

  // {kind[1:0], opcode[7:0], command REQs granted[3:0], expected step[2:0]}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 8'h12, 4'd6,  3'd4},
    {2'd0, 8'h28, 4'd10, 3'd4},
    {2'd1, 8'h5A, 4'd10, 3'd4},
    {2'd1, 8'hA8, 4'd12, 3'd4},
    {2'd0, 8'h28, 4'd4,  3'd3},
    {2'd0, 8'h12, 4'd0,  3'd0},
    {2'd3, 8'hE0, 4'd6,  3'd4},
    {2'd1, 8'h08, 4'd2,  3'd3}
  };

  int checks = 0, fails = 0;
  logic [7:0] mem [16];
  int pops = 0, base = 0, go_cnt = 0, done_cnt = 0;
  logic last_svc = 1'b0;
  logic [2:0] last_seq = 3'd0;

  assign hs_done_i = done_pulse;
  logic done_pulse = 1'b0;
  assign fifo_data_i = mem[(pops - base) & 15];

  scsi_sel_cmd_sender u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .req_i(req_i),
    .phase_i(phase_i), .fifo_data_i(fifo_data_i), .fifo_pop_o(fifo_pop_o),
    .hs_go_o(hs_go_o), .hs_byte_o(hs_byte_o), .hs_done_i(hs_done_i),
    .atn_o(atn_o), .busy_o(busy_o), .seq_step_o(seq_step_o),
    .done_o(done_o), .done_bus_svc_o(done_bus_svc_o));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (fifo_pop_o) pops <= pops + 1;
    if (hs_go_o) go_cnt <= go_cnt + 1;
    if (done_o) begin
      done_cnt <= done_cnt + 1;
      last_svc <= done_bus_svc_o;
      last_seq <= seq_step_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] op);
    case (op[7:5])
      3'd1, 3'd2: return 10;
      3'd5:       return 12;
      default:    return 6;
    endcase
  endfunction

  task automatic load(input bit with_msg, input logic [7:0] op);
    base = pops;
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'h40 + i);
    if (with_msg) begin mem[0] = MSG_BYTE; mem[1] = op; end
    else mem[0] = op;
  endtask

  task automatic do_start(input logic [1:0] k);
    @(negedge clk); kind_i = k; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
    chk(seq_step_o == 3'd0, "R2 step cleared", seq_step_o, 0);
    chk(atn_o == (k == 2'd1 || k == 2'd2), "R2 atn", atn_o, (k == 2'd1 || k == 2'd2));
  endtask

  task automatic grant(input logic [2:0] ph, input logic [7:0] exp_b, input string tag);
    bit seen = 0;
    @(negedge clk); req_i = 1'b1; phase_i = ph;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (hs_go_o) seen = 1;
    end
    chk(seen, {tag, " go"}, seen, 1);
    chk(hs_byte_o == exp_b && fifo_pop_o, {tag, " R11 byte"}, hs_byte_o, exp_b);
    @(negedge clk);
    chk(!hs_go_o, "R11 go one cycle", hs_go_o, 0);
    req_i = 1'b0;
    @(negedge clk); done_pulse = 1'b1;
    @(negedge clk); done_pulse = 1'b0;
  endtask

  task automatic finish_bus(input logic [2:0] exp_seq, input int d0);
    @(negedge clk); req_i = 1'b1; phase_i = PH_STAT;
    repeat (3) @(negedge clk);
    chk(done_cnt == d0, "R10 waits for REQ low", done_cnt, d0);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && last_svc == 1'b1, "R10 bus service", last_svc, 1);
    chk(last_seq == exp_seq, "R10 R9 final step", last_seq, exp_seq);
    chk(!busy_o, "R10 idle", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy_o && !atn_o && !hs_go_o && !fifo_pop_o && !done_o, "R1 outputs", busy_o, 0);
    chk(seq_step_o == 3'd0, "R1 step", seq_step_o, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] k  = VEC[v][16:15];
      logic [7:0] op = VEC[v][14:7];
      int n  = int'(VEC[v][6:3]);
      logic [2:0] es = VEC[v][2:0];
      bit msg = (k == 2'd1);
      int d0, g0, off;
      load(msg, op);
      do_start(k);
      d0 = done_cnt; g0 = go_cnt; off = msg ? 1 : 0;
      if (msg) begin
        grant(PH_MSG, MSG_BYTE, "R4 message");
        chk(atn_o == 1'b0, "R4 atn dropped", atn_o, 0);
        chk(seq_step_o == 3'd0, "R4 step after message", seq_step_o, 0);
      end
      for (int b = 0; b < n; b++) begin
        grant(PH_CMD, mem[b + off], "R3 command");
        if (b + 1 == exp_len(op))
          chk(seq_step_o == 3'd4, "R9 R7 step at last byte", seq_step_o, 4);
        else
          chk(seq_step_o == 3'd3, "R8 R7 step mid command", seq_step_o, 3);
      end
      chk(go_cnt - g0 == n + off, "R3 byte count", go_cnt - g0, n + off);
      finish_bus(es, d0);
    end

    begin
      int d0, g0;
      load(1'b1, 8'h12);
      do_start(2'd2);
      d0 = done_cnt; g0 = go_cnt;
      grant(PH_MSG, MSG_BYTE, "R6 message");
      @(negedge clk);
      chk(done_cnt == d0 + 1 && last_svc == 1'b0, "R6 function complete", last_svc, 0);
      chk(last_seq == 3'd1 && seq_step_o == 3'd1, "R6 step one", seq_step_o, 1);
      chk(atn_o == 1'b1, "R4 atn held for stop kind", atn_o, 1);
      chk(go_cnt - g0 == 1 && !busy_o, "R6 single byte", go_cnt - g0, 1);
    end

    begin
      int d0, g0;
      load(1'b1, 8'h12);
      do_start(2'd1);
      d0 = done_cnt; g0 = go_cnt;
      @(negedge clk); req_i = 1'b1; phase_i = PH_STAT;
      repeat (2) @(negedge clk);
      chk(done_cnt == d0 + 1 && last_svc == 1'b0, "R5 function complete", last_svc, 0);
      chk(go_cnt == g0, "R5 no byte", go_cnt - g0, 0);
      chk(seq_step_o == 3'd0 && !busy_o, "R5 step zero", seq_step_o, 0);
      req_i = 1'b0;
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule